// File: doc/BRIEF.md
# Protection-Key Register Write Unit

This unit executes the instruction that loads the 32-bit user protection-key register in a simple in-order core model. A decoded instruction arrives on a valid/ready handshake. The handshake carries the three opcode bytes, the prefix flags, the feature-enable control bit, a flag that marks the instruction as the oldest unretired operation, and the 64-bit A, C and D general registers. The instruction is classified in the cycle it is accepted. The unit then either reports an invalid-opcode fault, reports a general-protection fault, or sends the new key value down a fixed-latency commit pipeline.

Because the key controls access rights, the write is never speculative. The unit accepts an instruction only when the core marks it as the oldest. While any accepted write has not yet reached the register, a fence holds low the grant for memory accesses that depend on the key. The fence counts the writes in flight and releases the grant in the cycle in which the updated value becomes visible.

Top module: `pkey_write_unit`

## Requirements
- R1: After reset the key register reads 0, the commit pulse and both fault outputs are low, and `mem_grant` follows `mem_req`.
- R2: The instruction is recognised only when `in_opc` equals 24'h0F01EF, with bits [23:16] holding the first byte 0F, bits [15:8] holding 01 and bits [7:0] holding EF, and both `in_opsize` and `in_rep` are low. Any other opcode, or either prefix flag set, raises `ud_fault` and leaves the key unchanged.
- R3: When `in_feat_en` is 0, an accepted instruction raises `ud_fault` and leaves the key unchanged.
- R4: When `in_lock` is 1, an accepted instruction raises `ud_fault` and leaves the key unchanged.
- R5: When bits [31:0] of `in_reg_c` or of `in_reg_d` are nonzero, and no invalid-opcode condition applies, the unit raises `gp_fault` with `gp_errcode` equal to 0 and does not update the key.
- R6: When the conditions for both faults hold, only `ud_fault` is raised. The two fault outputs are never high together.
- R7: A fault-free instruction accepted at clock edge N loads bits [31:0] of `in_reg_a` into `key_q` at edge N+LAT. `commit` is high for exactly the cycle after that edge. Bits [63:32] of A, C and D have no effect on the result, and `key_q` changes at no other time.
- R8: `in_ready` equals `in_oldest`. While `in_oldest` is low, no instruction is accepted, no fault is raised and the key does not change.
- R9: `mem_grant` is low while any accepted write has not yet committed, including the cycle in which a fault-free write is being accepted. It goes high again in the cycle in which `commit` shows the last pending update.
- R10: A fault output is a one-cycle pulse in the cycle that follows the edge at which the faulting instruction was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Unit accepts the instruction this cycle |
| in_opc | input | 24 | Opcode bytes, first byte in the top bits |
| in_lock | input | 1 | LOCK prefix present |
| in_opsize | input | 1 | Operand-size prefix present |
| in_rep | input | 1 | Repeat prefix present |
| in_feat_en | input | 1 | Protection-key feature enable control bit |
| in_oldest | input | 1 | Instruction is the oldest unretired operation |
| in_reg_a | input | 64 | A register value (new key in the low half) |
| in_reg_c | input | 64 | C register value |
| in_reg_d | input | 64 | D register value |
| mem_req | input | 1 | Key-governed memory access request |
| mem_grant | output | 1 | Permission for that access |
| key_q | output | 32 | Key register read port |
| commit | output | 1 | One-cycle pulse after the key register updates |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_errcode | output | 16 | Error code for the general-protection fault |

## Verification
Three things can fall in the same cycle. A fault-free write can be accepted while a memory request is waiting. One write can commit while the next is accepted. One write can commit while the counter is about to drop to zero. The bench holds `mem_req` high through every operation and samples the grant in the accept cycle itself and after each edge of the pipeline. It also issues two writes on consecutive cycles, so that the first commit lands while the second is still in flight. It then checks that the grant stays low across the first commit and rises with the second, and that the key shows each value in turn.

// File: rtl/pkwu_pkg.sv
package pkwu_pkg;
  localparam int KEY_W = 32;
  localparam int GPR_W = 64;
  localparam int OPC_W = 24;
  localparam int ERR_W = 16;
  localparam logic [OPC_W-1:0] PKWU_OPC = 24'h0F01EF;

  typedef enum logic [1:0] {
    PK_OK = 2'd0,
    PK_UD = 2'd1,
    PK_GP = 2'd2
  } pk_kind_e;

  // invalid-opcode conditions: bad encoding, prefixes, lock, feature off
  function automatic logic pk_is_ud(input logic [OPC_W-1:0] opc,
                                    input logic lock, input logic opsize,
                                    input logic rep, input logic feat_en);
    logic enc_bad;
    enc_bad  = (opc != PKWU_OPC) | opsize | rep;
    pk_is_ud = enc_bad | lock | ~feat_en;
  endfunction

  // general-protection condition: nonzero low halves of C or D
  function automatic logic pk_is_gp(input logic [KEY_W-1:0] c_lo,
                                    input logic [KEY_W-1:0] d_lo);
    pk_is_gp = (|c_lo) | (|d_lo);
  endfunction

  function automatic pk_kind_e pk_classify(input logic ud, input logic gp);
    if (ud)      pk_classify = PK_UD;
    else if (gp) pk_classify = PK_GP;
    else         pk_classify = PK_OK;
  endfunction
endpackage

// File: rtl/pkwu_decode.sv
module pkwu_decode
  import pkwu_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             lock,
  input  logic             opsize,
  input  logic             rep,
  input  logic             feat_en,
  input  logic [KEY_W-1:0] c_lo,
  input  logic [KEY_W-1:0] d_lo,
  output pk_kind_e         kind
);
  logic ud_cond;
  logic gp_cond;

  always_comb begin
    ud_cond = pk_is_ud(opc, lock, opsize, rep, feat_en);
    gp_cond = pk_is_gp(c_lo, d_lo);
    kind    = pk_classify(ud_cond, gp_cond);
  end
endmodule

// File: rtl/pkwu_commit_pipe.sv
module pkwu_commit_pipe #(
  parameter int DEPTH = 3,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_val,
  output logic         out_vld,
  output logic [W-1:0] out_val
);
  logic         vld_q [DEPTH];
  logic [W-1:0] val_q [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      logic         nxt_vld;
      logic [W-1:0] nxt_val;
      if (g == 0) begin : g_head
        assign nxt_vld = in_vld;
        assign nxt_val = in_val;
      end else begin : g_body
        assign nxt_vld = vld_q[g-1];
        assign nxt_val = val_q[g-1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          val_q[g] <= '0;
        end else begin
          vld_q[g] <= nxt_vld;
          val_q[g] <= nxt_vld ? nxt_val : val_q[g];
        end
      end
    end
  endgenerate

  assign out_vld = vld_q[DEPTH-1];
  assign out_val = val_q[DEPTH-1];
endmodule

// File: rtl/pkwu_fence.sv
module pkwu_fence #(
  parameter int MAX_PEND = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic mem_req,
  output logic mem_grant,
  output logic pend_zero
);
  localparam int CW = $clog2(MAX_PEND + 1);

  logic [CW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else if (inc && !dec) pend_q <= pend_q + 1'b1;
    else if (dec && !inc) pend_q <= pend_q - 1'b1;
  end

  assign pend_zero = (pend_q == '0);
  // an access is blocked while a write is in flight or being accepted
  assign mem_grant = mem_req && pend_zero && !inc;
endmodule

// File: rtl/pkey_write_unit.sv
module pkey_write_unit
  import pkwu_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_opc,
  input  logic             in_lock,
  input  logic             in_opsize,
  input  logic             in_rep,
  input  logic             in_feat_en,
  input  logic             in_oldest,
  input  logic [GPR_W-1:0] in_reg_a,
  input  logic [GPR_W-1:0] in_reg_c,
  input  logic [GPR_W-1:0] in_reg_d,
  input  logic             mem_req,
  output logic             mem_grant,
  output logic [KEY_W-1:0] key_q,
  output logic             commit,
  output logic             ud_fault,
  output logic             gp_fault,
  output logic [ERR_W-1:0] gp_errcode
);
  pk_kind_e         kind;
  logic             accept;
  logic             accept_write;
  logic             pipe_out_vld;
  logic [KEY_W-1:0] pipe_out_val;
  logic             pend_zero;
  logic             unused_hi;

  // upper register halves take no part in the instruction
  assign unused_hi = ^{in_reg_a[GPR_W-1:KEY_W], in_reg_c[GPR_W-1:KEY_W],
                       in_reg_d[GPR_W-1:KEY_W]};

  assign in_ready     = in_oldest;
  assign accept       = in_valid && in_ready;
  assign accept_write = accept && (kind == PK_OK);

  pkwu_decode u_dec (
    .opc     (in_opc),
    .lock    (in_lock),
    .opsize  (in_opsize),
    .rep     (in_rep),
    .feat_en (in_feat_en),
    .c_lo    (in_reg_c[KEY_W-1:0]),
    .d_lo    (in_reg_d[KEY_W-1:0]),
    .kind    (kind)
  );

  pkwu_commit_pipe #(.DEPTH(LAT), .W(KEY_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (accept_write),
    .in_val  (in_reg_a[KEY_W-1:0]),
    .out_vld (pipe_out_vld),
    .out_val (pipe_out_val)
  );

  pkwu_fence #(.MAX_PEND(LAT)) u_fence (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (accept_write),
    .dec       (pipe_out_vld),
    .mem_req   (mem_req),
    .mem_grant (mem_grant),
    .pend_zero (pend_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q    <= '0;
      commit   <= 1'b0;
      ud_fault <= 1'b0;
      gp_fault <= 1'b0;
    end else begin
      if (pipe_out_vld) key_q <= pipe_out_val;
      commit   <= pipe_out_vld;
      ud_fault <= accept && (kind == PK_UD);
      gp_fault <= accept && (kind == PK_GP);
    end
  end

  assign gp_errcode = '0;
endmodule

// File: rtl/pkwu_chk.sv
module pkwu_chk
  import pkwu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             accept_write,
  input logic             pend_zero,
  input logic             mem_grant,
  input logic             commit,
  input logic [KEY_W-1:0] key_q,
  input logic             ud_fault,
  input logic             gp_fault
);
  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ud_fault && gp_fault));

  // R9
  grant_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant |-> (pend_zero && !accept_write));

  // R7
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |-> $stable(key_q));

  // R10
  fault_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_fault || gp_fault) |-> $past(in_valid && in_ready));

  // R8
  no_accept_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !(ud_fault || gp_fault));
endmodule

bind pkey_write_unit pkwu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .accept_write (accept_write),
  .pend_zero    (pend_zero),
  .mem_grant    (mem_grant),
  .commit       (commit),
  .key_q        (key_q),
  .ud_fault     (ud_fault),
  .gp_fault     (gp_fault)
);

// File: tb/pkey_write_unit_test.sv
module pkey_write_unit_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_lock, in_opsize, in_rep, in_feat_en, in_oldest;
  logic [23:0] in_opc;
  logic [63:0] in_reg_a, in_reg_c, in_reg_d;
  logic        mem_req, mem_grant, commit, ud_fault, gp_fault;
  logic [31:0] key_q;
  logic [15:0] gp_errcode;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_key = 32'h0;

  always #2.5 clk = ~clk;

  pkey_write_unit #(.LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc(in_opc), .in_lock(in_lock), .in_opsize(in_opsize), .in_rep(in_rep),
    .in_feat_en(in_feat_en), .in_oldest(in_oldest), .in_reg_a(in_reg_a),
    .in_reg_c(in_reg_c), .in_reg_d(in_reg_d), .mem_req(mem_req),
    .mem_grant(mem_grant), .key_q(key_q), .commit(commit), .ud_fault(ud_fault),
    .gp_fault(gp_fault), .gp_errcode(gp_errcode)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 = write, 1 = invalid opcode, 2 = protection fault
  function automatic int expect_kind(logic [23:0] opc, logic lk, logic os,
                                     logic rp, logic fe, logic [63:0] c,
                                     logic [63:0] d);
    if (lk || !fe || os || rp || opc[23:16] != 8'h0F || opc[15:8] != 8'h01 ||
        opc[7:0] != 8'hEF) return 1;
    if (c[31:0] != 0 || d[31:0] != 0) return 2;
    return 0;
  endfunction

  task automatic idle();
    in_valid = 0; in_oldest = 1; in_lock = 0; in_opsize = 0; in_rep = 0;
    in_feat_en = 1; in_opc = 24'h0F01EF; in_reg_a = 0; in_reg_c = 0; in_reg_d = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_one(logic [23:0] opc, logic lk, logic os, logic rp, logic fe,
                         logic [63:0] a, logic [63:0] c, logic [63:0] d);
    int k;
    k = expect_kind(opc, lk, os, rp, fe, c, d);
    in_valid = 1; in_oldest = 1; in_opc = opc; in_lock = lk; in_opsize = os;
    in_rep = rp; in_feat_en = fe; in_reg_a = a; in_reg_c = c; in_reg_d = d;
    mem_req = 1;
    #1;
    chk(mem_grant == (k != 0), "R9 grant in accept cycle", mem_grant, (k != 0));
    step();
    in_valid = 0;
    chk(ud_fault == (k == 1), "R2/R3/R4/R6 ud_fault", ud_fault, (k == 1));
    chk(gp_fault == (k == 2), "R5/R6 gp_fault", gp_fault, (k == 2));
    if (k == 2) chk(gp_errcode == 0, "R5 errcode", gp_errcode, 0);
    if (k == 0) begin
      for (int i = 1; i < LAT; i++) begin
        step();
        chk(!mem_grant && !commit, "R9 fence held", {mem_grant, commit}, 0);
        chk(ud_fault == 0, "R10 fault pulse width", ud_fault, 0);
      end
      step();
      model_key = a[31:0];
      chk(commit == 1, "R7 commit pulse", commit, 1);
      chk(key_q == model_key, "R7 key value", key_q, model_key);
      chk(mem_grant == 1, "R9 release", mem_grant, 1);
      step();
      chk(commit == 0, "R7 commit one cycle", commit, 0);
    end else begin
      chk(key_q == model_key, "R3/R4/R5 key unchanged", key_q, model_key);
      chk(commit == 0, "R5 no commit", commit, 0);
      chk(mem_grant == 1, "R9 grant free", mem_grant, 1);
      step();
      chk(!ud_fault && !gp_fault, "R10 fault one cycle", {ud_fault, gp_fault}, 0);
      for (int i = 0; i < LAT; i++) step();
      chk(key_q == model_key && !commit, "R2 no late write", key_q, model_key);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5EED_1234);
    idle(); mem_req = 1; rst_n = 0;
    repeat (3) step();
    rst_n = 1; step();
    // R1
    chk(key_q == 0, "R1 key reset", key_q, 0);
    chk(!commit && !ud_fault && !gp_fault, "R1 outputs idle",
        {commit, ud_fault, gp_fault}, 0);
    chk(mem_grant == 1, "R1 grant follows req", mem_grant, 1);
    mem_req = 0; #1;
    chk(mem_grant == 0, "R1 grant follows req low", mem_grant, 0);

    // directed
    run_one(24'h0F01EF, 0, 0, 0, 1, 64'hFFFF_FFFF_1234_5678,
            64'hAAAA_0000_0000_0000, 64'h5555_0000_0000_0000); // R7 upper ignored
    run_one(24'h0F01EF, 0, 0, 0, 0, 64'h1, 64'h0, 64'h0);      // R3
    run_one(24'h0F01EF, 1, 0, 0, 1, 64'h2, 64'h0, 64'h0);      // R4
    run_one(24'h0F01EE, 0, 0, 0, 1, 64'h3, 64'h0, 64'h0);      // R2 bad byte
    run_one(24'h0F01EF, 0, 1, 0, 1, 64'h4, 64'h0, 64'h0);      // R2 opsize
    run_one(24'h0F01EF, 0, 0, 1, 1, 64'h5, 64'h0, 64'h0);      // R2 rep
    run_one(24'h0F01EF, 0, 0, 0, 1, 64'h6, 64'h1, 64'h0);      // R5 C
    run_one(24'h0F01EF, 0, 0, 0, 1, 64'h7, 64'h0, 64'h8000_0000); // R5 D
    run_one(24'h0F01EF, 1, 0, 0, 1, 64'h8, 64'h1, 64'h1);      // R6 priority
    run_one(24'h0F01EF, 0, 0, 0, 1, 64'hDEAD_BEEF, 64'h0, 64'h0);

    // R8: not oldest, nothing accepted
    in_valid = 1; in_oldest = 0; in_feat_en = 0; #1;
    chk(in_ready == 0, "R8 ready low", in_ready, 0);
    step(); step();
    chk(!ud_fault && key_q == model_key, "R8 no effect", {ud_fault, key_q}, model_key);
    idle(); step();

    // R9 back-to-back writes: first commit while second in flight
    mem_req = 1;
    in_valid = 1; in_reg_a = 64'h1111; step();
    in_reg_a = 64'h2222; step();
    in_valid = 0;
    for (int i = 2; i < LAT; i++) step();
    step();
    chk(commit && key_q == 32'h1111, "R7 first of pair", key_q, 32'h1111);
    chk(mem_grant == 0, "R9 held for second", mem_grant, 0);
    step();
    chk(commit && key_q == 32'h2222, "R7 second of pair", key_q, 32'h2222);
    chk(mem_grant == 1, "R9 released after last", mem_grant, 1);
    model_key = 32'h2222;
    step();

    // constrained random
    for (int n = 0; n < 120; n++) begin
      logic [23:0] opc;
      logic [63:0] a, c, d;
      opc = ($urandom_range(0, 9) < 8) ? 24'h0F01EF : 24'(($urandom() & 32'hFFFFFF) ^ 32'h1);
      a = {$urandom(), $urandom()};
      c = {$urandom(), ($urandom_range(0, 9) < 2) ? $urandom() : 32'h0};
      d = {$urandom(), ($urandom_range(0, 9) < 2) ? $urandom() : 32'h0};
      run_one(opc, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
              $urandom_range(0, 9) == 0, $urandom_range(0, 9) != 0, a, c, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule